// File: doc/BRIEF.md
# Byte-Serial Instruction Cache Line Filler

This block sits between the fetch stage of a small coprocessor and its program memory. The core presents a program counter with a request flag. The block answers with an opcode byte and a ready flag. It also raises a stall flag while the byte is not yet available. Behind it is a direct-mapped instruction cache. The cache uses 16-byte lines, keeps one valid bit and one tag per line, and holds a byte data array. Lines are never loaded in a burst. Each byte is fetched with its own read over a request/acknowledge memory port.

On a miss inside the cacheable window, the block starts filling the line at offset 0. When the target offset is not 0, it first loads the bytes below the target while the core stalls. It then streams the rest of the line, handing each byte to the core as it arrives. If the core moves to any other address while a line is only partly loaded, the block stalls the core and completes that line before serving the new address. A line becomes usable only once its last byte (offset 15) has been stored. Addresses outside the window bypass the cache entirely. A flush clears every valid bit and drops any fill in progress.

Top module: `byte_line_filler`

## Requirements
- R1: A line covers 16 bytes at an address aligned to 16. It is loaded by one memory read per byte, at ascending addresses within that line.
- R2: A line's valid bit rises only in the cycle after the byte at offset 15 of that line is acknowledged. From then on, fetches to any byte of the line hit.
- R3: While a line is partly loaded, a request for any address other than the next sequential byte makes the block read every remaining byte of that line first. Only after that does it serve the new address.
- R4: A miss in the window at a nonzero offset reads offsets 0 up to the target, in order. The target byte is delivered on the acknowledge of its own read.
- R5: After a miss, each sequential fetch up to offset 15 costs exactly one memory read. The byte goes to the core in the acknowledge cycle.
- R6: A hit returns the stored byte with ready high in the same cycle as the request, and with no memory request.
- R7: A fetch outside the inclusive window from WIN_BASE to WIN_LIMIT issues one read at the fetch address and forwards its data. It changes no valid bit, and a repeated fetch reads memory again.
- R8: A flush clears all valid bits and abandons any fill. The next miss to the abandoned line restarts at offset 0.
- R9: stall_o is high in exactly the cycles where a fetch is requested and ready is low.
- R10: At most one read is outstanding. mem_req_o and mem_addr_o hold until mem_ack_i, unless a flush intervenes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all lines and drop any fill |
| fetch_req_i | input | 1 | Core requests the byte at fetch_pc_i |
| fetch_pc_i | input | ADDR_W | Program counter of the requested byte |
| fetch_ready_o | output | 1 | Requested byte is on fetch_byte_o this cycle |
| fetch_byte_o | output | 8 | Opcode byte |
| stall_o | output | 1 | Request pending, byte not available |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | ADDR_W | Memory read address |
| mem_ack_i | input | 1 | Read acknowledge; data valid this cycle |
| mem_data_i | input | 8 | Read data |

## Verification
A hit is due in the same cycle as its request. A bypass read or a streamed byte is due in the cycle that mem_ack_i rises, which the bench memory places a programmable number of wait cycles after the request. A miss adds one decision cycle before its first read. The bench therefore predicts every fetch's length as one cycle for a hit, L+2 for a single read, and 1+(n+1)(L+2) for a miss at offset n. It samples the outputs one nanosecond before each rising edge and compares that count, the byte and the logged read addresses against those formulas.

// File: rtl/icf_pkg.sv
package icf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PREFILL,
    ST_STREAM,
    ST_FINISH
  } fill_state_e;
endpackage

// File: rtl/icf_window.sv
module icf_window #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = '0,
  parameter logic [ADDR_W-1:0] LIMIT = '1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              inside_o
);
  generate
    if (BASE == '0) begin : g_lim_only
      assign inside_o = (addr_i <= LIMIT);
    end else begin : g_range
      assign inside_o = (addr_i >= BASE) && (addr_i <= LIMIT);
    end
  endgenerate
endmodule

// File: rtl/icf_tag_store.sv
module icf_tag_store #(
  parameter int NUM_LINES = 8,
  parameter int TAG_W = 9,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 flush_i,
  input  logic [IDX_W-1:0]     rd_idx_i,
  input  logic [TAG_W-1:0]     rd_tag_i,
  output logic                 hit_o,
  input  logic                 alloc_i,
  input  logic [IDX_W-1:0]     alloc_idx_i,
  input  logic [TAG_W-1:0]     alloc_tag_i,
  input  logic                 set_valid_i,
  input  logic [IDX_W-1:0]     set_idx_i,
  output logic [NUM_LINES-1:0] valid_o
);
  logic [TAG_W-1:0] tag_q [NUM_LINES];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     valid_o[g] <= 1'b0;
      else if (flush_i)                                valid_o[g] <= 1'b0;
      else if (alloc_i && alloc_idx_i == IDX_W'(g))    valid_o[g] <= 1'b0;
      else if (set_valid_i && set_idx_i == IDX_W'(g))  valid_o[g] <= 1'b1;
    end

    always_ff @(posedge clk_i) begin
      if (alloc_i && alloc_idx_i == IDX_W'(g)) tag_q[g] <= alloc_tag_i;
    end
  end

  assign hit_o = valid_o[rd_idx_i] && (tag_q[rd_idx_i] == rd_tag_i);
endmodule

// File: rtl/icf_data_array.sv
module icf_data_array #(
  parameter int NUM_LINES = 8,
  parameter int LINE_BYTES = 16,
  localparam int A_W = $clog2(NUM_LINES * LINE_BYTES)
) (
  input  logic           clk_i,
  input  logic           we_i,
  input  logic [A_W-1:0] waddr_i,
  input  logic [7:0]     wdata_i,
  input  logic [A_W-1:0] raddr_i,
  output logic [7:0]     rdata_o
);
  logic [7:0] mem_q [NUM_LINES * LINE_BYTES];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/byte_line_filler.sv
module byte_line_filler
  import icf_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LINE_BYTES = 16,
  parameter int NUM_LINES = 8,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h0000,
  parameter logic [ADDR_W-1:0] WIN_LIMIT = 16'h7FFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              fetch_req_i,
  input  logic [ADDR_W-1:0] fetch_pc_i,
  output logic              fetch_ready_o,
  output logic [7:0]        fetch_byte_o,
  output logic              stall_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ack_i,
  input  logic [7:0]        mem_data_i
);
  localparam int OFF_W   = $clog2(LINE_BYTES);
  localparam int IDX_W   = $clog2(NUM_LINES);
  localparam int LADDR_W = ADDR_W - OFF_W;
  localparam int TAG_W   = LADDR_W - IDX_W;

  fill_state_e state_q, state_d;
  logic [LADDR_W-1:0] fill_line_q, fill_line_d;
  logic [OFF_W-1:0]   fill_off_q, fill_off_d, tgt_off_q, tgt_off_d, off_inc;

  logic [OFF_W-1:0]   pc_off;
  logic [LADDR_W-1:0] pc_line;
  logic [IDX_W-1:0]   pc_idx;
  logic [TAG_W-1:0]   pc_tag;
  logic [ADDR_W-1:0]  fill_addr;
  logic               last_off;

  logic               in_win, hit;
  logic               alloc, set_valid, we;
  logic [NUM_LINES-1:0] valid_q;
  logic [7:0]         arr_rdata;

  assign pc_off    = fetch_pc_i[OFF_W-1:0];
  assign pc_line   = fetch_pc_i[ADDR_W-1:OFF_W];
  assign pc_idx    = pc_line[IDX_W-1:0];
  assign pc_tag    = pc_line[LADDR_W-1:IDX_W];
  assign fill_addr = {fill_line_q, fill_off_q};
  assign last_off  = (fill_off_q == '1);
  assign off_inc   = fill_off_q + 1'b1;

  icf_window #(.ADDR_W(ADDR_W), .BASE(WIN_BASE), .LIMIT(WIN_LIMIT)) u_win (
    .addr_i   (fetch_pc_i),
    .inside_o (in_win)
  );

  icf_tag_store #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W)) u_tags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush_i),
    .rd_idx_i    (pc_idx),
    .rd_tag_i    (pc_tag),
    .hit_o       (hit),
    .alloc_i     (alloc),
    .alloc_idx_i (pc_idx),
    .alloc_tag_i (pc_tag),
    .set_valid_i (set_valid),
    .set_idx_i   (fill_line_q[IDX_W-1:0]),
    .valid_o     (valid_q)
  );

  icf_data_array #(.NUM_LINES(NUM_LINES), .LINE_BYTES(LINE_BYTES)) u_data (
    .clk_i   (clk_i),
    .we_i    (we),
    .waddr_i ({fill_line_q[IDX_W-1:0], fill_off_q}),
    .wdata_i (mem_data_i),
    .raddr_i ({pc_idx, pc_off}),
    .rdata_o (arr_rdata)
  );

  always_comb begin
    state_d       = state_q;
    fill_line_d   = fill_line_q;
    fill_off_d    = fill_off_q;
    tgt_off_d     = tgt_off_q;
    mem_req_o     = 1'b0;
    mem_addr_o    = fill_addr;
    fetch_ready_o = 1'b0;
    fetch_byte_o  = mem_data_i;
    we            = 1'b0;
    alloc         = 1'b0;
    set_valid     = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (fetch_req_i) begin
          if (!in_win) begin
            // uncached path: straight through, no cache state touched
            mem_req_o     = 1'b1;
            mem_addr_o    = fetch_pc_i;
            fetch_ready_o = mem_ack_i;
          end else if (hit) begin
            fetch_ready_o = 1'b1;
            fetch_byte_o  = arr_rdata;
          end else begin
            alloc       = 1'b1;
            fill_line_d = pc_line;
            fill_off_d  = '0;
            tgt_off_d   = pc_off;
            state_d     = (pc_off == '0) ? ST_STREAM : ST_PREFILL;
          end
        end
      end
      ST_PREFILL: begin
        mem_req_o = 1'b1;
        if (mem_ack_i) begin
          we         = 1'b1;
          fill_off_d = off_inc;
          if (off_inc == tgt_off_q) state_d = ST_STREAM;
        end
      end
      ST_STREAM: begin
        if (fetch_req_i) begin
          if (fetch_pc_i == fill_addr) begin
            mem_req_o = 1'b1;
            if (mem_ack_i) begin
              we            = 1'b1;
              fetch_ready_o = 1'b1;
              if (last_off) begin
                set_valid = 1'b1;
                state_d   = ST_IDLE;
              end else begin
                fill_off_d = off_inc;
              end
            end
          end else begin
            // redirect inside a partial line: complete it first
            state_d = ST_FINISH;
          end
        end
      end
      ST_FINISH: begin
        mem_req_o = 1'b1;
        if (mem_ack_i) begin
          we = 1'b1;
          if (last_off) begin
            set_valid = 1'b1;
            state_d   = ST_IDLE;
          end else begin
            fill_off_d = off_inc;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase

    if (flush_i) begin
      state_d       = ST_IDLE;
      mem_req_o     = 1'b0;
      fetch_ready_o = 1'b0;
      we            = 1'b0;
      alloc         = 1'b0;
      set_valid     = 1'b0;
    end
  end

  assign stall_o = fetch_req_i && !fetch_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      fill_line_q <= '0;
      fill_off_q  <= '0;
      tgt_off_q   <= '0;
    end else begin
      state_q     <= state_d;
      fill_line_q <= fill_line_d;
      fill_off_q  <= fill_off_d;
      tgt_off_q   <= tgt_off_d;
    end
  end
endmodule

// File: rtl/icf_checker.sv
module icf_checker #(
  parameter int ADDR_W = 16,
  parameter int OFF_W = 4,
  parameter int NUM_LINES = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 flush_i,
  input logic                 fetch_req_i,
  input logic [ADDR_W-1:0]    fetch_pc_i,
  input logic                 fetch_ready_o,
  input logic [7:0]           fetch_byte_o,
  input logic                 mem_req_o,
  input logic [ADDR_W-1:0]    mem_addr_o,
  input logic                 mem_ack_i,
  input logic [7:0]           mem_data_i,
  input logic                 in_win,
  input logic [NUM_LINES-1:0] valid_q
);
  assert_valid_on_last_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((valid_q & ~$past(valid_q)) != '0) |->
      $past(mem_ack_i && mem_req_o && (&mem_addr_o[OFF_W-1:0])));

  assert_hit_no_mem_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_ready_o && !mem_ack_i) |-> !mem_req_o);

  assert_bypass_fwd_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_ack_i && mem_req_o && fetch_req_i && !in_win && !flush_i &&
     mem_addr_o == fetch_pc_i) |-> (fetch_ready_o && fetch_byte_o == mem_data_i));

  assert_flush_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (valid_q == '0));

  assert_req_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i && !flush_i) |=>
      (flush_i || (mem_req_o && $stable(mem_addr_o))));
endmodule

bind byte_line_filler icf_checker #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .NUM_LINES(NUM_LINES)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .flush_i       (flush_i),
  .fetch_req_i   (fetch_req_i),
  .fetch_pc_i    (fetch_pc_i),
  .fetch_ready_o (fetch_ready_o),
  .fetch_byte_o  (fetch_byte_o),
  .mem_req_o     (mem_req_o),
  .mem_addr_o    (mem_addr_o),
  .mem_ack_i     (mem_ack_i),
  .mem_data_i    (mem_data_i),
  .in_win        (in_win),
  .valid_q       (valid_q)
);

// File: tb/sim_byte_line_filler.sv
module sim_byte_line_filler;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        req = 1'b0;
  logic [15:0] pc = '0;
  logic        ready, stall, mreq, ack_q;
  logic [7:0]  fbyte, mdata;
  logic [15:0] maddr;

  int lat = 0;
  int wait_cnt = 0;
  int rd_cnt = 0;
  logic [15:0] rlog [1024];
  int total = 0, fails = 0;
  int stall_err = 0, hold_err = 0;
  logic pend_q = 1'b0;
  logic [15:0] pend_addr = '0;
  bit done = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] memf(input logic [15:0] a);
    return (a[7:0] * 8'd13) ^ a[15:8] ^ 8'h5A;
  endfunction

  assign mdata = ack_q ? memf(maddr) : 8'h00;

  byte_line_filler #(
    .ADDR_W(16), .LINE_BYTES(16), .NUM_LINES(4),
    .WIN_BASE(16'h0000), .WIN_LIMIT(16'h00FF)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .fetch_req_i(req), .fetch_pc_i(pc),
    .fetch_ready_o(ready), .fetch_byte_o(fbyte), .stall_o(stall),
    .mem_req_o(mreq), .mem_addr_o(maddr),
    .mem_ack_i(ack_q), .mem_data_i(mdata)
  );

  // memory model with programmable wait, plus read log and hold monitor
  always @(posedge clk) begin
    ack_q <= 1'b0;
    if (mreq && !ack_q) begin
      if (wait_cnt >= lat) begin ack_q <= 1'b1; wait_cnt <= 0; end
      else wait_cnt <= wait_cnt + 1;
    end else if (!mreq) wait_cnt <= 0;
    if (mreq && ack_q) begin
      rlog[rd_cnt[9:0]] <= maddr;
      rd_cnt <= rd_cnt + 1;
    end
    if (rst_n && pend_q && !flush && (!mreq || maddr != pend_addr)) hold_err <= hold_err + 1;
    pend_q    <= rst_n && mreq && !ack_q && !flush;
    pend_addr <= maddr;
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic fetch(input logic [15:0] a, output logic [7:0] b, output int cyc);
    @(negedge clk);
    pc = a; req = 1'b1; cyc = 0; b = 8'h00;
    forever begin
      #3;
      cyc++;
      if (stall == ready) stall_err++;
      if (ready) begin
        b = fbyte;
        @(negedge clk);
        req = 1'b0;
        break;
      end
      if (cyc > 2000) break;
      @(negedge clk);
    end
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    int cyc, mark, bad;
    repeat (3) @(negedge clk);
    #3;
    chk(!stall && !mreq && !ready, "R9 reset idle", {stall, mreq, ready}, 0);
    rst_n = 1'b1;
    lat = 1;

    // R1 R2 R5 R6: sequential fill of line 0x20, then hits
    mark = rd_cnt; bad = 0;
    fetch(16'h0020, b, cyc);
    chk(cyc == 1 + 1 * (lat + 2) && b == memf(16'h0020), "R1 first byte cycles", cyc, 1 + (lat + 2));
    for (int i = 1; i < 16; i++) begin
      fetch(16'h0020 + 16'(i), b, cyc);
      if (cyc != lat + 2 || b != memf(16'h0020 + 16'(i))) bad++;
    end
    chk(bad == 0 && rd_cnt - mark == 16, "R5 stream 0x20 line", rd_cnt - mark, 16);
    bad = 0;
    for (int i = 0; i < 16; i++)
      if (rlog[10'(mark + i)] != 16'h0020 + 16'(i)) bad++;
    chk(bad == 0, "R1 ascending addresses", bad, 0);
    mark = rd_cnt; bad = 0;
    for (int i = 15; i >= 0; i--) begin
      fetch(16'h0020 + 16'(i), b, cyc);
      if (cyc != 1 || b != memf(16'h0020 + 16'(i))) bad++;
    end
    chk(bad == 0 && rd_cnt == mark, "R6 R2 hits after line complete", rd_cnt - mark, 0);

    // R4: miss at offset 5
    mark = rd_cnt;
    fetch(16'h0035, b, cyc);
    chk(cyc == 1 + 6 * (lat + 2) && b == memf(16'h0035), "R4 prefill cycles", cyc, 1 + 6 * (lat + 2));
    bad = 0;
    for (int i = 0; i < 6; i++) if (rlog[10'(mark + i)] != 16'h0030 + 16'(i)) bad++;
    chk(bad == 0 && rd_cnt - mark == 6, "R4 prefill order", rd_cnt - mark, 6);
    mark = rd_cnt; bad = 0;
    for (int i = 6; i < 16; i++) begin
      fetch(16'h0030 + 16'(i), b, cyc);
      if (cyc != lat + 2 || b != memf(16'h0030 + 16'(i))) bad++;
    end
    chk(bad == 0 && rd_cnt - mark == 10, "R5 stream after prefill", rd_cnt - mark, 10);
    mark = rd_cnt;
    fetch(16'h0033, b, cyc);
    chk(cyc == 1 && rd_cnt == mark && b == memf(16'h0033), "R2 line 0x30 valid", rd_cnt - mark, 0);

    // R3: redirect in the middle of a fill
    lat = 0;
    fetch(16'h0040, b, cyc);
    fetch(16'h0041, b, cyc);
    fetch(16'h0042, b, cyc);
    mark = rd_cnt;
    fetch(16'h0095, b, cyc);
    chk(rd_cnt - mark == 19 && b == memf(16'h0095), "R3 finish then target", rd_cnt - mark, 19);
    bad = 0;
    for (int i = 0; i < 13; i++) if (rlog[10'(mark + i)] != 16'h0043 + 16'(i)) bad++;
    for (int i = 0; i < 6; i++) if (rlog[10'(mark + 13 + i)] != 16'h0090 + 16'(i)) bad++;
    chk(bad == 0, "R3 read order", bad, 0);
    mark = rd_cnt;
    fetch(16'h0047, b, cyc);
    chk(rd_cnt - mark == 10 && rlog[10'(mark)] == 16'h0096 && b == memf(16'h0047),
        "R3 jump from prefilled line", rd_cnt - mark, 10);

    // R7: bypass outside window
    lat = 2;
    for (int k = 0; k < 2; k++) begin
      mark = rd_cnt;
      fetch(16'h1234, b, cyc);
      chk(rd_cnt - mark == 1 && rlog[10'(mark)] == 16'h1234 && cyc == lat + 2 && b == memf(16'h1234),
          "R7 bypass read", cyc, lat + 2);
    end
    mark = rd_cnt;
    fetch(16'h004C, b, cyc);
    chk(cyc == 1 && rd_cnt == mark, "R7 cache untouched", rd_cnt - mark, 0);

    // R8: flush clears valid and abandons fill
    lat = 0;
    do_flush();
    mark = rd_cnt;
    fetch(16'h0047, b, cyc);
    chk(rd_cnt - mark == 8 && b == memf(16'h0047), "R8 miss after flush", rd_cnt - mark, 8);
    fetch(16'h0048, b, cyc);
    do_flush();
    mark = rd_cnt;
    fetch(16'h0049, b, cyc);
    chk(rd_cnt - mark == 10 && rlog[10'(mark)] == 16'h0040 && b == memf(16'h0049),
        "R8 abandoned fill restarts", rd_cnt - mark, 10);

    // sweep of every target offset, three memory latencies
    for (int off = 0; off < 16; off++) begin
      logic [15:0] base;
      int b1, b2;
      base = 16'(off * 16);
      lat = off % 3;
      do_flush();
      mark = rd_cnt;
      fetch(base + 16'(off), b, cyc);
      bad = 0;
      for (int i = 0; i <= off; i++) if (rlog[10'(mark + i)] != base + 16'(i)) bad++;
      chk(bad == 0 && rd_cnt - mark == off + 1 && cyc == 1 + (off + 1) * (lat + 2) &&
          b == memf(base + 16'(off)), "R4 sweep miss", cyc, 1 + (off + 1) * (lat + 2));
      b1 = 0;
      mark = rd_cnt;
      for (int i = off + 1; i < 16; i++) begin
        fetch(base + 16'(i), b, cyc);
        if (cyc != lat + 2 || b != memf(base + 16'(i))) b1++;
      end
      chk(b1 == 0 && rd_cnt - mark == 15 - off, "R5 sweep stream", rd_cnt - mark, 15 - off);
      b2 = 0;
      mark = rd_cnt;
      for (int i = 0; i < 16; i++) begin
        fetch(base + 16'(i), b, cyc);
        if (cyc != 1 || b != memf(base + 16'(i))) b2++;
      end
      chk(b2 == 0 && rd_cnt == mark, "R2 sweep hits", rd_cnt - mark, 0);
    end

    chk(stall_err == 0, "R9 stall tracks ready", stall_err, 0);
    chk(hold_err == 0, "R10 request held until ack", hold_err, 0);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule